// File: doc/BRIEF.md
# Serial Port with Deep Receive Buffer

This block is an asynchronous serial transmitter and receiver for a small system-on-chip. The bit rate is set when the design is built, as a clock-cycle divisor equal to the clock frequency over the bit rate. For example, an 18 MHz clock at 62500 bit/s gives a divisor of 288. The number of data bits and stop bits are also build-time parameters. Software cannot change any of them.

Incoming frames are found by a start-bit detector. Each bit is sampled at its centre, and every good byte is stored in a deep receive FIFO, so software can collect bytes whenever it suits it. A word-addressed register port gives software five views. Three belong to the receive side: the buffer state, the oldest byte (popped on read) and the fill count. Two belong to the transmit side: whether it can take a byte, and where to write the byte to send.

Top module: `serial_port`

## Requirements
- R1: After reset, `tx_o` is high, the receive status (0x20) and fill count (0x22) read 0, and the transmit status (0x40) reads 1.
- R2: Every bit on `tx_o` lasts exactly `CLK_DIV` cycles. A frame is one low start bit, then `DATA_BITS` data bits least significant first, then `STOP_BITS` high bits.
- R3: The receiver samples each data bit at its centre and stores the byte. A read of 0x21 returns the oldest stored byte in the low bits of `rdata_o` and removes it in the same access. Read data appears on `rdata_o` in the cycle after the access.
- R4: A read of 0x22 returns the number of bytes held in the receive FIFO.
- R5: Bit 0 of a read of 0x20 is 1 exactly when the receive FIFO is not empty.
- R6: Bit 0 of a read of 0x40 is 1 when the transmitter is idle. When it is idle, a write to 0x41 starts a frame in the cycle after the write. A write to 0x41 while a frame is in flight is ignored.
- R7: A low pulse on `rx_i` that is high again by the half-bit recheck is discarded, and no byte is stored.
- R8: A byte that completes while the FIFO holds `FIFO_DEPTH` bytes is dropped, and the stored bytes and their order are kept.
- R9: A frame whose first stop bit samples low is discarded.
- R10: A read of 0x21 while the FIFO is empty returns 0 and leaves the fill count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |

## Verification
The bench builds the block with a divisor of 8, eight data bits, one stop bit and an eight-entry FIFO. The short divisor makes an off-by-one bit counter push the tenth receive sample past the edge of a bit. It also lets a frame-by-frame model of the transmit line expose any change of bit length on every clock. The eight-entry FIFO puts the overflow case within reach in a few frames. That case covers both the dropped byte and the survivors read back in order, along with glitch and framing rejection.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam logic [7:0] ADDR_RX_STAT  = 8'h20;
  localparam logic [7:0] ADDR_RX_DATA  = 8'h21;
  localparam logic [7:0] ADDR_RX_COUNT = 8'h22;
  localparam logic [7:0] ADDR_TX_STAT  = 8'h40;
  localparam logic [7:0] ADDR_TX_DATA  = 8'h41;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/ser_rx.sv
module ser_rx import serial_pkg::*; #(
  parameter int CLK_DIV   = 288,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic                 push_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int CW   = $clog2(CLK_DIV + 1);
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic rx_m, rx_s, rx_prev_q;
  rx_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic push_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_prev_q <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      rx_prev_q <= rx_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      shift_q <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (rx_prev_q && !rx_s) st_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q <= rx_s ? RX_IDLE : RX_DATA;  // glitch rejected
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == CW'(CLK_DIV - 1)) begin
            cnt_q <= '0;
            shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
            if (bit_q == BW'(DATA_BITS - 1)) st_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == CW'(CLK_DIV - 1)) begin
            cnt_q <= '0;
            push_q <= rx_s;  // framing error drops the byte
            st_q <= RX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign push_o = push_q;
  assign data_o = shift_q;

  p_bit_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_DATA && cnt_q == CW'(CLK_DIV - 1)) |=> cnt_q == '0);
  p_glitch_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_START && cnt_q == CW'(HALF - 1) && rx_s) |=> (st_q == RX_IDLE && !push_q));
  p_frame_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_STOP && cnt_q == CW'(CLK_DIV - 1) && !rx_s) |=> !push_o);
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int CLK_DIV   = 288,
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 ready_o,
  output logic                 tx_o
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam int FW = 1 + DATA_BITS + STOP_BITS;
  localparam int IW = $clog2(FW);

  logic busy_q, tx_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [FW-1:0] shift_q;
  logic [FW-1:0] frame;

  assign frame = {{STOP_BITS{1'b1}}, data_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tx_q <= 1'b1;
      cnt_q <= '0;
      idx_q <= '0;
      shift_q <= '1;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        tx_q <= frame[0];
        shift_q <= {1'b1, frame[FW-1:1]};
        cnt_q <= '0;
        idx_q <= '0;
      end
    end else if (cnt_q == CW'(CLK_DIV - 1)) begin
      cnt_q <= '0;
      if (idx_q == IW'(FW - 1)) begin
        busy_q <= 1'b0;
        tx_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
        tx_q <= shift_q[0];
        shift_q <= {1'b1, shift_q[FW-1:1]};
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = !busy_q;
  assign tx_o = tx_q;

  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != CW'(CLK_DIV - 1)) |=> $stable(shift_q));
  p_idle_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_o);
endmodule

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [WIDTH-1:0]         wdata_i,
  input  logic                     pop_i,
  output logic [WIDTH-1:0]         rdata_o,
  output logic                     empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [NW-1:0] cnt_q;
  logic [WIDTH-1:0] dout_q;
  logic do_push, do_pop, full;

  assign full = (cnt_q == NW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
    if (do_pop) dout_q <= mem_q[rd_q];  // synchronous read, fits block RAM
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop) rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10: cnt_q <= cnt_q + 1'b1;
        2'b01: cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign rdata_o = dout_q;
  assign count_o = cnt_q;

  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (count_o == $past(count_o)));
  p_pop_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && pop_i && !push_i) |=> (count_o == $past(count_o) - 1'b1));
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/serial_port.sv
module serial_port import serial_pkg::*; #(
  parameter int CLK_DIV    = 288,
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 1,
  parameter int FIFO_DEPTH = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  output logic        tx_o,
  input  logic        cs_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int NW = $clog2(FIFO_DEPTH + 1);

  logic rx_push, fifo_empty, tx_ready, pop, rd_en, tx_start, sel_fifo_q;
  logic [DATA_BITS-1:0] rx_data, fifo_dout;
  logic [NW-1:0] fifo_cnt;
  logic [31:0] reg_q;

  ser_rx #(.CLK_DIV(CLK_DIV), .DATA_BITS(DATA_BITS)) i_rx (
    .clk_i, .rst_ni, .rx_i, .push_o(rx_push), .data_o(rx_data)
  );

  ser_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_BITS)) i_fifo (
    .clk_i, .rst_ni, .push_i(rx_push), .wdata_i(rx_data), .pop_i(pop),
    .rdata_o(fifo_dout), .empty_o(fifo_empty), .count_o(fifo_cnt)
  );

  ser_tx #(.CLK_DIV(CLK_DIV), .DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) i_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .data_i(wdata_i[DATA_BITS-1:0]),
    .ready_o(tx_ready), .tx_o
  );

  assign rd_en = cs_i && !we_i;
  assign pop = rd_en && (addr_i == ADDR_RX_DATA);
  assign tx_start = cs_i && we_i && (addr_i == ADDR_TX_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      sel_fifo_q <= 1'b0;
    end else begin
      sel_fifo_q <= pop && !fifo_empty;
      if (rd_en) begin
        case (addr_i)
          ADDR_RX_STAT:  reg_q <= {31'b0, !fifo_empty};
          ADDR_RX_COUNT: reg_q <= 32'(fifo_cnt);
          ADDR_TX_STAT:  reg_q <= {31'b0, tx_ready};
          default:       reg_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = sel_fifo_q ? {{(32-DATA_BITS){1'b0}}, fifo_dout} : reg_q;
endmodule

// File: tb/test_serial_port.sv
module test_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int DB = 8;
  localparam int SB = 1;
  localparam int DEPTH = 8;
  localparam int NB = 1 + DB + SB;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, cs = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic tx;
  logic [31:0] rdata;

  int total = 0, bad = 0;
  bit done = 0;
  int exp_q[$];

  serial_port #(.CLK_DIV(DIV), .DATA_BITS(DB), .STOP_BITS(SB), .FIFO_DEPTH(DEPTH)) i_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model of the transmit line
  bit m_busy = 0;
  int m_k = 0;
  logic [NB-1:0] m_frame = '1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0;
    end else if (m_busy) begin
      m_k++;
      if (m_k == NB * DIV) m_busy = 0;
    end else if (cs && we && addr == 8'h41) begin
      m_busy = 1; m_k = 0;
      m_frame = {{SB{1'b1}}, wdata[DB-1:0], 1'b0};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_tx;
      exp_tx = m_busy ? m_frame[m_k / DIV] : 1'b1;
      check(tx === exp_tx, "R2 tx line", int'(tx), int'(exp_tx));
    end
  end

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output bit ready_exp);
    @(negedge clk);
    ready_exp = !m_busy;
    cs = 1; we = 0; addr = a;
    @(negedge clk);
    cs = 0;
    d = rdata;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic send_rx(input logic [DB-1:0] b, input bit stop_ok);
    logic [NB-1:0] f;
    f = {{SB{stop_ok}}, b, 1'b0};
    for (int i = 0; i < NB; i++) begin
      @(negedge clk); rx = f[i];
      repeat (DIV - 1) @(negedge clk);
    end
    @(negedge clk); rx = 1'b1;
    repeat (DIV) @(negedge clk);
    if (stop_ok && exp_q.size() < DEPTH) exp_q.push_back(int'(b));
  endtask

  task automatic check_count(input string req);
    logic [31:0] d; bit r;
    bus_read(8'h22, d, r);
    check(d == 32'(exp_q.size()), req, int'(d), exp_q.size());
  endtask

  task automatic drain(input string req);
    logic [31:0] d; bit r;
    while (exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      bus_read(8'h21, d, r);
      check(d == 32'(e), req, int'(d), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; bit r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(tx === 1'b1, "R1 tx idle", int'(tx), 1);
    bus_read(8'h20, d, r); check(d == 0, "R1 rx status", int'(d), 0);
    bus_read(8'h22, d, r); check(d == 0, "R1 count", int'(d), 0);
    bus_read(8'h40, d, r); check(d == 1, "R1 tx status", int'(d), 1);

    // R6 transmit, busy write ignored
    bus_write(8'h41, 32'hA5);
    bus_write(8'h41, 32'h3C);
    bus_read(8'h40, d, r); check(d == 32'(r), "R6 tx busy status", int'(d), int'(r));
    check(d == 0, "R6 tx not ready", int'(d), 0);
    repeat (NB * DIV) @(negedge clk);
    bus_read(8'h40, d, r); check(d == 1, "R6 tx ready again", int'(d), 1);
    bus_write(8'h41, 32'h3C);
    repeat (NB * DIV + 2) @(negedge clk);
    bus_write(8'h41, 32'h1FF);
    repeat (NB * DIV + 2) @(negedge clk);

    // R3 R4 R5 receive back-to-back
    send_rx(8'h55, 1);
    send_rx(8'hA3, 1);
    check_count("R4 count two");
    bus_read(8'h20, d, r); check(d == 1, "R5 status nonempty", int'(d), 1);
    drain("R3 rx data order");
    check_count("R4 count after pops");
    bus_read(8'h20, d, r); check(d == 0, "R5 status empty", int'(d), 0);

    // R10 empty read
    bus_read(8'h21, d, r); check(d == 0, "R10 empty data", int'(d), 0);
    check_count("R10 count stays zero");

    // R7 glitch
    @(negedge clk); rx = 1'b0;
    repeat (2) @(negedge clk); rx = 1'b1;
    repeat (NB * DIV * 2) @(negedge clk);
    check_count("R7 glitch rejected");

    // R9 framing error then good frame
    send_rx(8'h12, 0);
    repeat (DIV * 2) @(negedge clk);
    check_count("R9 bad stop dropped");
    send_rx(8'h81, 1);
    check_count("R9 recovery count");
    drain("R9 recovery data");

    // R8 overflow
    for (int i = 0; i <= DEPTH; i++) send_rx(DB'(8'h30 + i), 1);
    check_count("R8 full count");
    drain("R8 survivors in order");
    check_count("R8 drained");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule